// File: doc/BRIEF.md
# Protected-Mode Interrupt Gate Dispatcher

This block carries out the entry half of a protected-mode interrupt. It takes a request that carries an 8-bit vector, a flag telling an external source from a software one, an optional error code, the current privilege level and the live EFLAGS, CS, EIP and stack pointer. It keeps a table register, holding a 32-bit base and a 16-bit limit, that software loads and reads back. From that register it computes the address of the 8-byte gate for the vector. It then fetches the gate as two 32-bit reads and checks it.

When the gate is an interrupt or trap gate, the block pushes the return frame through a memory write port and returns the handler's CS, EIP and EFLAGS together with the final stack pointer. When the gate is a task gate, the block only raises a task-switch indication carrying the gate's selector. Any check that fails ends in a general-protection fault, and the fault's error code names the vector and the source. The block does not switch stacks, does not check segment descriptors and does not perform the task switch itself.

Top module: `idt_gate_dispatch`

## Requirements
- R1: After reset the table base and the table limit read back as 0. A load pulse writes both, and from the next cycle on they read back as the loaded values.
- R2: The gate for vector v sits at base + 8·v, with 32-bit wraparound. The block fetches it as exactly two reads: the low word from that address, then the high word from that address + 4.
- R3: When 8·v + 7 exceeds the limit, the request faults without any memory read. The fault code is 8·v + 2 + e, where e is 1 for an external source and 0 for a software source.
- R4: The gate also faults, with the same code and with no write, in any of these cases: the present bit (bit 47) is 0, bit 44 is 1, bits 39:32 are not all zero, or the type field in bits 43:40 is not one of 0x5, 0x6, 0x7, 0xE or 0xF.
- R5: A software request whose privilege level is numerically greater than the gate privilege in bits 46:45 faults. An external request skips this check.
- R6: For type 0xE or 0xF, the block writes 4-byte words at sp−4, sp−8 and sp−12. These hold, in order, EFLAGS, CS zero-extended and EIP. When an error code is present, it goes to sp−16. The new EIP is {bits 63:48, bits 15:0}, the new CS is bits 31:16, and the new stack pointer is the last address written.
- R7: For type 0x6 or 0x7, every push is a 2-byte write (half flag 1) with a step of 2. Its data is the low 16 bits of the item, zero-extended. The new EIP is bits 15:0, zero-extended.
- R8: An interrupt gate (0x6 or 0xE) returns EFLAGS with bit 9 cleared. A trap gate (0x7 or 0xF) returns EFLAGS unchanged. The pushed EFLAGS is always the value that came in with the request.
- R9: A valid task gate (0x5) raises the task-switch flag with the selector from bits 31:16. It performs no write and raises no fault.
- R10: Busy is high from the cycle after a request is accepted through the cycle of the done pulse. Done lasts exactly one cycle. A request presented while busy is ignored.
- R11: A read or write request stays asserted with a stable address, and for a write stable data, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_ld | input | 1 | Load pulse for the table register |
| tbl_ld_base | input | 32 | Base value to load |
| tbl_ld_limit | input | 16 | Limit value to load (table bytes − 1) |
| tbl_base | output | 32 | Table base read-back |
| tbl_limit | output | 16 | Table limit read-back |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Vector number |
| req_ext | input | 1 | 1 = external source, 0 = software |
| req_has_err | input | 1 | Push an error code |
| req_err | input | 32 | Error code value |
| req_cpl | input | 2 | Current privilege level |
| req_eflags | input | 32 | Current EFLAGS |
| req_cs | input | 16 | Current CS |
| req_eip | input | 32 | Current EIP |
| req_esp | input | 32 | Current stack pointer |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read accepted, rd_data valid |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data (zero-extended when half) |
| wr_half | output | 1 | 1 = 2-byte write, 0 = 4-byte write |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | General-protection fault on completion |
| fault_code | output | 32 | Fault error code |
| new_cs | output | 16 | Handler CS |
| new_eip | output | 32 | Handler EIP |
| new_eflags | output | 32 | Handler EFLAGS |
| new_esp | output | 32 | Stack pointer after the pushes |
| task_sw | output | 1 | Task-switch request |
| task_sel | output | 16 | Task gate selector |

## Verification
The bench builds the block with its default settings, in which bit 9 is the interrupt-enable position. It sweeps all 256 vectors twice. The first sweep uses a 200-entry table, so the upper vectors reach the limit fault. The second sweep uses a full table whose base sits just below the top of the address space, so the entry addresses wrap. The descriptors are generated from the vector number, so the sweeps cover every gate type, every reserved-field violation, every privilege pairing for both sources and both frame widths, all under random ready stalls.

// File: rtl/idt_pkg.sv
package idt_pkg;
  typedef enum logic [1:0] {GK_NONE, GK_TASK, GK_INTR, GK_TRAP} gate_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_EVAL, ST_PUSH, ST_DONE} seq_state_e;

  // gate address: eight bytes per entry
  function automatic logic [31:0] entry_addr(input logic [31:0] base, input logic [7:0] vec);
    return base + {21'd0, vec, 3'd0};
  endfunction

  // last byte of the entry must lie within the limit
  function automatic logic in_limit(input logic [15:0] lim, input logic [7:0] vec);
    return {5'd0, vec, 3'b111} <= lim;
  endfunction

  // fault code: entry offset, table-reference bit, source bit
  function automatic logic [31:0] gp_code(input logic [7:0] vec, input logic ext);
    return {21'd0, vec, 1'b0, 1'b1, ext};
  endfunction

  // frame item by slot, narrowed for 16-bit gates
  function automatic logic [31:0] frame_item(input logic [1:0] slot, input logic [31:0] efl,
                                             input logic [15:0] cs, input logic [31:0] eip,
                                             input logic [31:0] err, input logic wide);
    logic [31:0] v;
    case (slot)
      2'd0:    v = efl;
      2'd1:    v = {16'd0, cs};
      2'd2:    v = eip;
      default: v = err;
    endcase
    return wide ? v : {16'd0, v[15:0]};
  endfunction
endpackage

// File: rtl/idt_base_reg.sv
module idt_base_reg #(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  output logic [BASE_W-1:0] base_q,
  output logic [LIM_W-1:0]  limit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (ld) begin
      base_q  <= ld_base;
      limit_q <= ld_limit;
    end
  end

  // R1
  tbl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (base_q == $past(ld_base)) && (limit_q == $past(ld_limit)));
endmodule

// File: rtl/idt_gate_check.sv
module idt_gate_check import idt_pkg::*; (
  input  logic [63:0] desc,
  input  logic [1:0]  cpl,
  input  logic        ext,
  output logic        gate_ok,
  output gate_kind_e  kind,
  output logic        wide,
  output logic [15:0] sel,
  output logic [31:0] target
);
  logic [3:0] ty;
  logic       type_known, shape_ok, priv_ok;

  always_comb begin
    ty         = desc[43:40];
    type_known = (ty == 4'h5) || (ty == 4'h6) || (ty == 4'h7) ||
                 (ty == 4'hE) || (ty == 4'hF);
    shape_ok   = desc[47] && !desc[44] && (desc[39:32] == 8'd0);
    priv_ok    = ext || (cpl <= desc[46:45]);
    gate_ok    = type_known && shape_ok && priv_ok;
    wide       = ty[3];
    if (!type_known)     kind = GK_NONE;
    else if (ty == 4'h5) kind = GK_TASK;
    else if (ty[0])      kind = GK_TRAP;
    else                 kind = GK_INTR;
    sel    = desc[31:16];
    target = wide ? {desc[63:48], desc[15:0]} : {16'd0, desc[15:0]};
  end
endmodule

// File: rtl/idt_gate_dispatch.sv
module idt_gate_dispatch import idt_pkg::*; #(
  parameter int IF_POS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_ld,
  input  logic [31:0] tbl_ld_base,
  input  logic [15:0] tbl_ld_limit,
  output logic [31:0] tbl_base,
  output logic [15:0] tbl_limit,
  input  logic        req_valid,
  input  logic [7:0]  req_vector,
  input  logic        req_ext,
  input  logic        req_has_err,
  input  logic [31:0] req_err,
  input  logic [1:0]  req_cpl,
  input  logic [31:0] req_eflags,
  input  logic [15:0] req_cs,
  input  logic [31:0] req_eip,
  input  logic [31:0] req_esp,
  output logic        busy,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        wr_half,
  input  logic        wr_ready,
  output logic        done,
  output logic        fault,
  output logic [31:0] fault_code,
  output logic [15:0] new_cs,
  output logic [31:0] new_eip,
  output logic [31:0] new_eflags,
  output logic [31:0] new_esp,
  output logic        task_sw,
  output logic [15:0] task_sel
);
  localparam logic [31:0] IF_MASK = 32'd1 << IF_POS;

  seq_state_e  st;
  logic [7:0]  vec_q;
  logic        ext_q, herr_q, wide_q, intr_q, fault_q, task_q;
  logic [1:0]  cpl_q, slot_q;
  logic [31:0] err_q, efl_q, eip_q, esp_q, ent_q, lo_q, hi_q, off_q, nefl_q, code_q;
  logic [15:0] cs_q, sel_q;

  // named events
  logic        accept, lim_ok, rd_fire, wr_fire, last_slot;
  logic [31:0] push_step, push_addr;

  logic        g_ok, g_wide;
  gate_kind_e  g_kind;
  logic [15:0] g_sel;
  logic [31:0] g_target;

  idt_base_reg #(.BASE_W(32), .LIM_W(16)) u_tbl (
    .clk(clk), .rst_n(rst_n), .ld(tbl_ld), .ld_base(tbl_ld_base),
    .ld_limit(tbl_ld_limit), .base_q(tbl_base), .limit_q(tbl_limit));

  idt_gate_check u_chk (
    .desc({hi_q, lo_q}), .cpl(cpl_q), .ext(ext_q), .gate_ok(g_ok),
    .kind(g_kind), .wide(g_wide), .sel(g_sel), .target(g_target));

  always_comb begin
    accept    = (st == ST_IDLE) && req_valid;
    lim_ok    = in_limit(tbl_limit, req_vector);
    rd_valid  = (st == ST_RD_LO) || (st == ST_RD_HI);
    rd_addr   = (st == ST_RD_HI) ? ent_q + 32'd4 : ent_q;
    rd_fire   = rd_valid && rd_ready;
    push_step = wide_q ? 32'd4 : 32'd2;
    push_addr = esp_q - push_step;
    wr_valid  = (st == ST_PUSH);
    wr_addr   = push_addr;
    wr_data   = frame_item(slot_q, efl_q, cs_q, eip_q, err_q, wide_q);
    wr_half   = !wide_q;
    wr_fire   = wr_valid && wr_ready;
    last_slot = slot_q == (herr_q ? 2'd3 : 2'd2);
    busy      = (st != ST_IDLE);
    done      = (st == ST_DONE);
  end

  assign fault      = fault_q;
  assign fault_code = code_q;
  assign new_cs     = sel_q;
  assign new_eip    = off_q;
  assign new_eflags = nefl_q;
  assign new_esp    = esp_q;
  assign task_sw    = task_q;
  assign task_sel   = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      vec_q <= '0; ext_q <= 1'b0; herr_q <= 1'b0; cpl_q <= '0;
      err_q <= '0; efl_q <= '0; cs_q <= '0; eip_q <= '0; esp_q <= '0;
      ent_q <= '0; lo_q <= '0; hi_q <= '0; off_q <= '0; nefl_q <= '0;
      code_q <= '0; sel_q <= '0; slot_q <= '0;
      wide_q <= 1'b0; intr_q <= 1'b0; fault_q <= 1'b0; task_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          vec_q   <= req_vector;
          ext_q   <= req_ext;
          herr_q  <= req_has_err;
          err_q   <= req_err;
          cpl_q   <= req_cpl;
          efl_q   <= req_eflags;
          cs_q    <= req_cs;
          eip_q   <= req_eip;
          esp_q   <= req_esp;
          ent_q   <= entry_addr(tbl_base, req_vector);
          code_q  <= gp_code(req_vector, req_ext);
          task_q  <= 1'b0;
          intr_q  <= 1'b0;
          fault_q <= !lim_ok;
          st      <= lim_ok ? ST_RD_LO : ST_DONE;
        end
        ST_RD_LO: if (rd_fire) begin
          lo_q <= rd_data;
          st   <= ST_RD_HI;
        end
        ST_RD_HI: if (rd_fire) begin
          hi_q <= rd_data;
          st   <= ST_EVAL;
        end
        ST_EVAL: begin
          sel_q <= g_sel;
          if (!g_ok) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else if (g_kind == GK_TASK) begin
            task_q <= 1'b1;
            st     <= ST_DONE;
          end else begin
            wide_q <= g_wide;
            off_q  <= g_target;
            intr_q <= (g_kind == GK_INTR);
            nefl_q <= (g_kind == GK_INTR) ? (efl_q & ~IF_MASK) : efl_q;
            slot_q <= 2'd0;
            st     <= ST_PUSH;
          end
        end
        ST_PUSH: if (wr_fire) begin
          esp_q  <= push_addr;
          slot_q <= slot_q + 2'd1;
          if (last_slot) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy);
  // R3
  lim_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lim_ok) |=> (done && fault && !rd_valid));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R8
  intr_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && !task_sw && intr_q) |-> !new_eflags[IF_POS]);
  // R9
  task_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fault && task_sw));
endmodule

// File: tb/idt_gate_dispatch_test.sv
`timescale 1ns/1ps
module idt_gate_dispatch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tbl_ld = 1'b0;
  logic [31:0] tbl_ld_base = '0;
  logic [15:0] tbl_ld_limit = '0;
  logic [31:0] tbl_base;
  logic [15:0] tbl_limit;
  logic        req_valid = 1'b0, req_ext = 1'b0, req_has_err = 1'b0;
  logic [7:0]  req_vector = '0;
  logic [31:0] req_err = '0, req_eflags = '0, req_eip = '0, req_esp = '0;
  logic [1:0]  req_cpl = '0;
  logic [15:0] req_cs = '0;
  logic        busy, rd_valid, wr_valid, wr_half, done, fault, task_sw;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, fault_code, new_eip, new_eflags, new_esp;
  logic [15:0] new_cs, task_sel;
  logic [31:0] cur_base = '0;

  int checks = 0, errors = 0;
  int rcnt = 0, wcnt = 0;
  logic [31:0] r_addr [0:3];
  logic [31:0] w_addr [0:7];
  logic [31:0] w_data [0:7];
  logic        w_half [0:7];
  logic [15:0] lfsr = 16'hACE1;

  idt_gate_dispatch uut (.*);

  function automatic logic [63:0] mk_desc(input logic [7:0] v);
    logic [3:0] ty; logic p, s; logic [1:0] dpl; logic [7:0] z;
    logic [15:0] sel; logic [31:0] off;
    p = 1'b1; s = 1'b0; z = 8'd0; dpl = v[4:3]; ty = 4'hE;
    case (v[2:0])
      3'd0: ty = 4'hE;
      3'd1: ty = 4'hF;
      3'd2: ty = 4'h6;
      3'd3: ty = 4'h7;
      3'd4: ty = 4'h5;
      3'd5: begin ty = 4'hE; p = 1'b0; end
      3'd6: case (v[4:3]) 2'd0: ty = 4'h0; 2'd1: ty = 4'h9; 2'd2: ty = 4'hC; default: ty = 4'h1; endcase
      default: if (v[3]) s = 1'b1; else begin z = v | 8'h01; ty = 4'hF; end
    endcase
    sel = {4'h1, v, 4'h8};
    off = {~v, 8'hA5, v, 8'h3C};
    return {off[31:16], p, dpl, s, ty, z, sel, off[15:0]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] o; logic [63:0] d;
    o = a - b;
    d = mk_desc(o[10:3]);
    return o[2] ? d[63:32] : d[31:0];
  endfunction

  assign rd_data = mem_word(rd_addr, cur_base);

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = lfsr[0] | lfsr[3];
    wr_ready = lfsr[1] | lfsr[4];
    if (rd_valid && rd_ready) begin
      if (rcnt < 4) r_addr[rcnt] = rd_addr;
      rcnt++;
    end
    if (wr_valid && wr_ready) begin
      if (wcnt < 8) begin
        w_addr[wcnt] = wr_addr; w_data[wcnt] = wr_data; w_half[wcnt] = wr_half;
      end
      wcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_tbl(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_ld = 1'b1; tbl_ld_base = b; tbl_ld_limit = l;
    @(negedge clk);
    tbl_ld = 1'b0;
    cur_base = b;
    chk("R1 base readback", tbl_base, b);
    chk("R1 limit readback", {16'd0, tbl_limit}, {16'd0, l});
  endtask

  task automatic run_one(input logic [7:0] v, input int pass, input logic [15:0] lim,
                         input logic [31:0] base, input bit disturb);
    logic ext, herr, inl, okd, wide, isint;
    logic [1:0] cpl;
    logic [31:0] err, efl, eip, esp, code, step, exp_eip, exp_efl;
    logic [15:0] cs;
    logic [63:0] d;
    logic [3:0] ty;
    int n;
    logic [31:0] items [0:3];
    ext  = ((int'(v) + pass) % 3) == 0;
    cpl  = v[6:5] + pass[1:0];
    herr = v[1] ^ v[5];
    err  = {16'hE000, v, pass[7:0]};
    efl  = {16'h0, v, 8'h02} ^ ((pass != 0) ? 32'h200 : 32'h0);
    cs   = 16'h0010 + {8'd0, v};
    eip  = {v, 24'h401000};
    esp  = 32'h0009_0000 + 32'(v) * 64;
    code = 32'(v) * 8 + 2 + 32'(ext);
    inl  = (32'(v) * 8 + 7) <= 32'(lim);

    @(negedge clk);
    rcnt = 0; wcnt = 0;
    req_valid = 1'b1; req_vector = v; req_ext = ext; req_has_err = herr; req_err = err;
    req_cpl = cpl; req_eflags = efl; req_cs = cs; req_eip = eip; req_esp = esp;
    @(negedge clk);
    if (disturb) begin
      req_vector = v ^ 8'h01; req_esp = 32'h1234_5670;
      chk("R10 busy after accept", 32'(busy), 32'd1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);

    d  = mk_desc(v);
    ty = d[43:40];
    okd = d[47] && !d[44] && (d[39:32] == 8'd0) &&
          (ty == 4'h5 || ty == 4'h6 || ty == 4'h7 || ty == 4'hE || ty == 4'hF) &&
          (ext || (cpl <= d[46:45]));
    if (!inl) begin
      chk("R3 limit fault", 32'(fault), 32'd1);
      chk("R3 fault code", fault_code, code);
      chk("R3 no read", 32'(rcnt), 32'd0);
      chk("R3 no write", 32'(wcnt), 32'd0);
    end else begin
      chk("R2 read count", 32'(rcnt), 32'd2);
      chk("R2 low addr", r_addr[0], base + 32'(v) * 8);
      chk("R2 high addr", r_addr[1], base + 32'(v) * 8 + 4);
      if (!okd) begin
        chk("R4 R5 gate fault", 32'(fault), 32'd1);
        chk("R4 R5 fault code", fault_code, code);
        chk("R4 no write", 32'(wcnt), 32'd0);
        chk("R9 no task on fault", 32'(task_sw), 32'd0);
      end else if (ty == 4'h5) begin
        chk("R9 task flag", 32'(task_sw), 32'd1);
        chk("R9 task sel", {16'd0, task_sel}, {16'd0, d[31:16]});
        chk("R9 no fault", 32'(fault), 32'd0);
        chk("R9 no write", 32'(wcnt), 32'd0);
      end else begin
        wide  = ty[3];
        isint = !ty[0];
        step  = wide ? 32'd4 : 32'd2;
        n     = herr ? 4 : 3;
        items[0] = efl; items[1] = {16'd0, cs}; items[2] = eip; items[3] = err;
        exp_eip = wide ? {d[63:48], d[15:0]} : {16'd0, d[15:0]};
        exp_efl = isint ? (efl & ~32'h200) : efl;
        chk("R6 no fault", 32'(fault), 32'd0);
        chk("R6 no task", 32'(task_sw), 32'd0);
        chk("R6 new cs", {16'd0, new_cs}, {16'd0, d[31:16]});
        chk(wide ? "R6 new eip" : "R7 new eip", new_eip, exp_eip);
        chk("R8 new eflags", new_eflags, exp_efl);
        chk("R6 write count", 32'(wcnt), 32'(n));
        chk("R6 new esp", new_esp, esp - step * 32'(n));
        for (int i = 0; i < n && i < wcnt; i++) begin
          chk(wide ? "R6 push addr" : "R7 push addr", w_addr[i], esp - step * 32'(i + 1));
          chk(wide ? "R6 push data" : "R7 push data", w_data[i],
              wide ? items[i] : {16'd0, items[i][15:0]});
          chk("R7 half flag", 32'(w_half[i]), 32'(!wide));
        end
      end
    end
    @(negedge clk);
    chk("R10 done one cycle", 32'(done), 32'd0);
    if (disturb) begin
      @(negedge clk);
      chk("R10 busy request ignored", 32'(busy), 32'd0);
      chk("R10 no stray read", 32'(rcnt), inl ? 32'd2 : 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset base", tbl_base, 32'd0);
    chk("R1 reset limit", {16'd0, tbl_limit}, 32'd0);
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    // R3: empty table after reset, vector 0 exceeds limit 0
    run_one(8'd0, 0, 16'd0, 32'd0, 1'b0);
    load_tbl(32'h0000_2000, 16'd1599);
    for (int v = 0; v < 256; v++) run_one(8'(v), 0, 16'd1599, 32'h0000_2000, 1'b0);
    load_tbl(32'hFFFF_FC00, 16'h07FF);
    for (int v = 0; v < 256; v++) run_one(8'(v), 1, 16'h07FF, 32'hFFFF_FC00, 1'b0);
    // R10: requests held during busy are ignored
    run_one(8'd1, 1, 16'h07FF, 32'hFFFF_FC00, 1'b1);
    run_one(8'd14, 1, 16'h07FF, 32'hFFFF_FC00, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule